// File: doc/BRIEF.md
# Windowed Bank Mapper with Operating-System Overlay

This block extends the reach of an 8-bit CPU with a 16-bit address bus. One aligned window of the address space, 16K by default, does not map to local memory. Accesses to it are sent to one of many external banks. For most code, the bank comes from a page register that software writes at a fixed I/O address. An access outside the window passes through unmapped: the window-hit pin stays low and the bank output reads zero.

The block also watches the opcode-fetch strobe. On every opcode fetch it records whether the instruction came from the operating-system region, and it keeps that record until the next fetch. Whenever the record is set, every window access inside that instruction goes to a fixed overlay bank instead of the page-register bank. A system routine can therefore reach its private memory through the window without saving and restoring the page register. During the fetch cycle itself, the fetch address's own region test decides the bank.

All outputs are combinational from the current bus cycle and the two stored items, the page register and the region flag. The CPU bus is a plain per-cycle bus with no handshake, so there is no valid/ready interface and no back-pressure. The CPU presents one bus cycle per clock.

Top module: `bankwin_top`

## Requirements
- R1: `win_hit` is 1 exactly when `cpu_addr` lies in the window from 0x8000 to 0xBFFF (default parameters). Both ends are inclusive, and the pin is 0 at 0x7FFF and at 0xC000.
- R2: When `win_hit` is 0, `ext_bank` is 0, whatever the page register and the region flag hold.
- R3: A cycle with `cpu_addr` = 0xFE30 and `cpu_rnw` = 0 (a write) loads `cpu_wdata` into the page register at that clock edge. The new value appears on the next window access. A read cycle at 0xFE30 leaves the register unchanged.
- R4: On a cycle with `cpu_sync` = 1, the region flag is set if `cpu_addr` lies in the system region from 0xE000 to 0xFFFF (both ends inclusive) and cleared otherwise. Cycles with `cpu_sync` = 0 never change the flag, even when they address the system region.
- R5: A window access with `cpu_sync` = 0 while the region flag is set drives `ext_bank` to the overlay bank, 0x80 by default. This holds for reads and for writes.
- R6: A window access with `cpu_sync` = 0 while the region flag is clear drives `ext_bank` to the page-register value.
- R7: On an opcode fetch from the window (`cpu_sync` = 1), the fetch address's own region test selects the bank, not the stored flag. A fetch from inside the window therefore gets the page-register bank even right after a system-region fetch.
- R8: A reset (`rst_n` = 0) clears the page register to 0 and clears the region flag. This also applies to a reset given in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one CPU bus cycle per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address of the current bus cycle |
| cpu_sync | input | 1 | High on an opcode-fetch cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_wdata | input | 8 | CPU write data; used for page-register writes |
| win_hit | output | 1 | High when the current address falls in the window |
| ext_bank | output | 8 | Bank number for a window access; 0 otherwise |

## Verification
`win_hit` and `ext_bank` follow the current bus cycle in the same cycle. A page-register write or a region-flag capture takes effect in the cycle after the edge that stores it. The bench drives each bus cycle on the falling edge and samples the outputs two nanoseconds later, before the next rising edge. Each stored effect is therefore checked on the vector that follows the one that caused it. The vector order sets up every flag and register state before the window access that depends on it.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  // Which source drives the external bank number in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PAGE = 2'd1,
    SRC_OVL  = 2'd2
  } bank_src_e;

endpackage

// File: rtl/bankwin_range_dec.sv
module bankwin_range_dec #(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] LO     = '0,
  parameter logic [ADDR_W-1:0] HI     = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  // Pick the cheapest comparison that the bounds allow.
  generate
    if (LO == HI) begin : g_single
      assign hit = (addr == LO);
    end else if (HI == ALL_ONES) begin : g_top
      assign hit = (addr >= LO);
    end else begin : g_span
      assign hit = (addr >= LO) && (addr <= HI);
    end
  endgenerate

endmodule

// File: rtl/bankwin_page_reg.sv
module bankwin_page_reg #(
  parameter int BANK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_data,
  output logic [BANK_W-1:0] page_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
    end else if (wr_en) begin
      page_q <= wr_data;
    end
  end

endmodule

// File: rtl/bankwin_os_track.sv
module bankwin_os_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fetch,
  input  logic in_os,
  output logic os_q,
  output logic os_eff
);

  // Sampled on each opcode fetch and held until the next one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      os_q <= 1'b0;
    end else if (fetch) begin
      os_q <= in_os;
    end
  end

  // The fetch cycle uses its own address's region test.
  assign os_eff = fetch ? in_os : os_q;

endmodule

// File: rtl/bankwin_bank_mux.sv
module bankwin_bank_mux
  import bankwin_pkg::*;
#(
  parameter int                BANK_W   = 8,
  parameter logic [BANK_W-1:0] OVL_BANK = 8'h80
) (
  input  logic              win_hit,
  input  logic              os_eff,
  input  logic [BANK_W-1:0] page_q,
  output logic [BANK_W-1:0] ext_bank
);

  bank_src_e src;

  always_comb begin
    if (!win_hit)    src = SRC_NONE;
    else if (os_eff) src = SRC_OVL;
    else             src = SRC_PAGE;
  end

  always_comb begin
    unique case (src)
      SRC_PAGE: ext_bank = page_q;
      SRC_OVL:  ext_bank = OVL_BANK;
      default:  ext_bank = '0;
    endcase
  end

endmodule

// File: rtl/bankwin_top.sv
module bankwin_top #(
  parameter int                ADDR_W    = 16,
  parameter int                BANK_W    = 8,
  parameter int                WIN_LOG2  = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h8000,
  parameter logic [ADDR_W-1:0] OS_LO     = 16'hE000,
  parameter logic [ADDR_W-1:0] OS_HI     = 16'hFFFF,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 16'hFE30,
  parameter logic [BANK_W-1:0] OVL_BANK  = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_sync,
  input  logic              cpu_rnw,
  input  logic [BANK_W-1:0] cpu_wdata,
  output logic              win_hit,
  output logic [BANK_W-1:0] ext_bank
);

  localparam logic [ADDR_W-1:0] WIN_LAST =
    ADDR_W'(int'(WIN_BASE) + (2 ** WIN_LOG2) - 1);

  logic              os_now;
  logic              page_sel;
  logic              page_wr;
  logic              os_q;
  logic              os_eff;
  logic [BANK_W-1:0] page_q;

  bankwin_range_dec #(.ADDR_W(ADDR_W), .LO(WIN_BASE), .HI(WIN_LAST)) u_win_dec (
    .addr (cpu_addr),
    .hit  (win_hit)
  );

  bankwin_range_dec #(.ADDR_W(ADDR_W), .LO(OS_LO), .HI(OS_HI)) u_os_dec (
    .addr (cpu_addr),
    .hit  (os_now)
  );

  bankwin_range_dec #(.ADDR_W(ADDR_W), .LO(PAGE_ADDR), .HI(PAGE_ADDR)) u_reg_dec (
    .addr (cpu_addr),
    .hit  (page_sel)
  );

  assign page_wr = page_sel && !cpu_rnw;

  bankwin_page_reg #(.BANK_W(BANK_W)) u_page (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (page_wr),
    .wr_data (cpu_wdata),
    .page_q  (page_q)
  );

  bankwin_os_track u_os (
    .clk    (clk),
    .rst_n  (rst_n),
    .fetch  (cpu_sync),
    .in_os  (os_now),
    .os_q   (os_q),
    .os_eff (os_eff)
  );

  bankwin_bank_mux #(.BANK_W(BANK_W), .OVL_BANK(OVL_BANK)) u_mux (
    .win_hit  (win_hit),
    .os_eff   (os_eff),
    .page_q   (page_q),
    .ext_bank (ext_bank)
  );

endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk #(
  parameter int                BANK_W   = 8,
  parameter logic [BANK_W-1:0] OVL_BANK = 8'h80
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_sync,
  input logic              page_wr,
  input logic [BANK_W-1:0] cpu_wdata,
  input logic              win_hit,
  input logic              os_now,
  input logic              os_q,
  input logic [BANK_W-1:0] page_q,
  input logic [BANK_W-1:0] ext_bank
);

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> ext_bank == '0);

  assert_page_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr |=> page_q == $past(cpu_wdata));

  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_sync |=> $stable(os_q));

  assert_overlay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !cpu_sync && os_q) |-> ext_bank == OVL_BANK);

  assert_page_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !cpu_sync && !os_q) |-> ext_bank == page_q);

  assert_fetch_own_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && cpu_sync && !os_now) |-> ext_bank == page_q);

endmodule

bind bankwin_top bankwin_chk #(.BANK_W(BANK_W), .OVL_BANK(OVL_BANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_sync  (cpu_sync),
  .page_wr   (page_wr),
  .cpu_wdata (cpu_wdata),
  .win_hit   (win_hit),
  .os_now    (os_now),
  .os_q      (os_q),
  .page_q    (page_q),
  .ext_bank  (ext_bank)
);

// File: tb/bankwin_top_tb.sv
module bankwin_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_sync = 1'b0;
  logic        cpu_rnw = 1'b1;
  logic [7:0]  cpu_wdata = '0;
  logic        win_hit;
  logic [7:0]  ext_bank;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bankwin_top u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_sync  (cpu_sync),
    .cpu_rnw   (cpu_rnw),
    .cpu_wdata (cpu_wdata),
    .win_hit   (win_hit),
    .ext_bank  (ext_bank)
  );

  // Vector fields: addr, sync, rnw, wdata, expected hit, expected bank, requirement number.
  localparam int NV = 24;
  localparam logic [38:0] VEC [NV] = '{
    {16'h9000, 1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd8}, // R8 page clear after reset
    {16'h1234, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 outside window
    {16'hFE30, 1'b0, 1'b0, 8'h05, 1'b0, 8'h00, 4'd3}, // R3 write page = 05
    {16'hA000, 1'b0, 1'b1, 8'h00, 1'b1, 8'h05, 4'd3}, // R3 new page seen
    {16'hFE30, 1'b0, 1'b1, 8'h0C, 1'b0, 8'h00, 4'd3}, // R3 read leaves page
    {16'hBFFF, 1'b0, 1'b1, 8'h00, 1'b1, 8'h05, 4'd1}, // R1 top edge
    {16'hC000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 4'd1}, // R1 past top
    {16'h7FFF, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 4'd1}, // R1 below base
    {16'h8000, 1'b0, 1'b1, 8'h00, 1'b1, 8'h05, 4'd1}, // R1 base
    {16'hE100, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4}, // R4 system fetch
    {16'h8800, 1'b0, 1'b1, 8'h00, 1'b1, 8'h80, 4'd5}, // R5 overlay read
    {16'h0200, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 4'd2}, // R2 data write elsewhere
    {16'h8801, 1'b0, 1'b0, 8'h00, 1'b1, 8'h80, 4'd5}, // R5 overlay write
    {16'h0400, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4}, // R4 user fetch
    {16'h8802, 1'b0, 1'b1, 8'h00, 1'b1, 8'h05, 4'd6}, // R6 page bank
    {16'hE000, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4}, // R4 non-fetch in system region
    {16'h8803, 1'b0, 1'b1, 8'h00, 1'b1, 8'h05, 4'd4}, // R4 flag unchanged
    {16'h9000, 1'b1, 1'b1, 8'h00, 1'b1, 8'h05, 4'd7}, // R7 fetch in window
    {16'hFFFF, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4}, // R4 system top edge
    {16'h8000, 1'b1, 1'b1, 8'h00, 1'b1, 8'h05, 4'd7}, // R7 window fetch after system
    {16'hFE30, 1'b0, 1'b0, 8'hF3, 1'b0, 8'h00, 4'd3}, // R3 write page = F3
    {16'h8000, 1'b0, 1'b1, 8'h00, 1'b1, 8'hF3, 4'd6}, // R6 new page
    {16'hDFFF, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, 4'd4}, // R4 just below system region
    {16'h9000, 1'b0, 1'b1, 8'h00, 1'b1, 8'hF3, 4'd4}  // R4 flag clear
  };

  task automatic drive(input logic [15:0] a, input logic s, input logic rw, input logic [7:0] wd);
    @(negedge clk);
    cpu_addr  = a;
    cpu_sync  = s;
    cpu_rnw   = rw;
    cpu_wdata = wd;
    #2;
  endtask

  task automatic check(input int req, input logic eh, input logic [7:0] eb);
    n_run++;
    if (win_hit !== eh || ext_bank !== eb) begin
      n_fail++;
      $display("FAIL R%0d addr=%h hit=%b bank=%h expected hit=%b bank=%h",
               req, cpu_addr, win_hit, ext_bank, eh, eb);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][38:23], VEC[i][22], VEC[i][21], VEC[i][20:13]);
      check(int'(VEC[i][3:0]), VEC[i][12], VEC[i][11:4]);
    end

    // R8: reset in mid-run clears both the page register and the flag.
    drive(16'hFE30, 1'b0, 1'b0, 8'h37);
    drive(16'hE200, 1'b1, 1'b1, 8'h00);
    drive(16'h8100, 1'b0, 1'b1, 8'h00);
    check(5, 1'b1, 8'h80);          // R5 overlay before reset
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(16'h8100, 1'b0, 1'b1, 8'h00);
    check(8, 1'b1, 8'h00);          // R8 flag clear and page zero

    // R3: write and then read back at once across consecutive cycles.
    drive(16'hFE30, 1'b0, 1'b0, 8'hAA);
    check(2, 1'b0, 8'h00);          // R2 register address is outside window
    drive(16'hBFFE, 1'b0, 1'b1, 8'h00);
    check(3, 1'b1, 8'hAA);          // R3 value on next cycle

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule